// File: doc/BRIEF.md
# ATA PIO Host Cycle Engine

This block is the host side of a parallel ATA port. Software sets the cycle timing: an enable, the address-setup, strobe and hold lengths for programmed-I/O cycles, and separate strobe and hold lengths for cycles that use the DMA request/acknowledge handshake. A command write then starts one bus cycle, or a train of cycles when the multi-word flag is set. Each command carries the register address, the direction, a data word, a stream select and a handshake select. With the stream select set, write words are taken from a transmit stream and read words are handed to a receive stream, instead of using the command word and the status word.

The status outputs show a busy flag, a one-cycle transmitter-ready pulse at the end of every word, a data-available flag and the last word read. Their order is fixed. On the last word, transmitter-ready comes exactly one cycle before busy falls. Software that polls busy and ready together therefore never misses the end of a transfer.

Top module: `ata_pio_host`

## Requirements
- R1: After reset, busy, transmitter-ready, data-available, chip-select, both strobes and the read word are all zero, and the enable is clear.
- R2: In each word, chip-select and the command address are driven for `setup` cycles with no strobe. The strobe is then high for `strobe` cycles (a value of 0 gives 1 cycle). Chip-select and the address then stay for `hold` cycles. A setup or hold of 0 removes that phase. The address does not change while chip-select is high, and the two strobes are never high together.
- R3: A read samples the bus data at the clock edge where the read strobe falls. In the first cycle after that edge, data-available is 1 and the read word holds the sampled value. The next accepted command clears data-available.
- R4: A write drives the data word, with output-enable high, in every strobe cycle. The word comes from the command when the stream select is 0.
- R5: Transmitter-ready is a single-cycle pulse that follows the hold phase of every word. When busy falls, transmitter-ready was high in the cycle before.
- R6: Busy rises in the first cycle after an accepted command. With no handshake waits, a transfer keeps busy high for words × (2 + setup + max(strobe,1) + hold) cycles.
- R7: With the multi-word flag set, the engine runs the number of words given in the transfer-count register (17 bits, up to 65536), and busy stays high from the first word to the last. A count of 0 runs one word. With the flag clear, exactly one word runs.
- R8: While the enable is clear, a command write starts no cycle and busy stays low.
- R9: A command write that arrives while busy is high is ignored. The running transfer keeps its address and its word count.
- R10: With the handshake select set, each word waits for the DMA request input and has no setup phase. It uses the DMA strobe and hold lengths, and the acknowledge output is high whenever chip-select is high.
- R11: With the stream select set, a write word starts only when the transmit valid is high. The word is then taken from the transmit data in the one wait cycle where ready is high. A read word appears on the receive data with a one-cycle receive-valid pulse, in the same cycle that data-available sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cfg_wr_i | input | 1 | Load the timing configuration |
| cfg_en_i | input | 1 | Enable bit to load |
| cfg_pio_setup_i | input | 5 | PIO address-setup cycles |
| cfg_pio_strobe_i | input | 5 | PIO strobe cycles |
| cfg_pio_hold_i | input | 5 | PIO hold cycles |
| cfg_dma_strobe_i | input | 5 | Handshake-mode strobe cycles |
| cfg_dma_hold_i | input | 5 | Handshake-mode hold cycles |
| cnt_wr_i | input | 1 | Load the transfer count |
| cnt_words_i | input | 17 | Words per multi-word transfer |
| cmd_wr_i | input | 1 | Command write, launches a transfer |
| cmd_addr_i | input | 3 | Drive register address |
| cmd_read_i | input | 1 | 1 = read, 0 = write |
| cmd_data_i | input | 16 | Write data word |
| cmd_stream_i | input | 1 | Data from/to the streams instead of the registers |
| cmd_multi_i | input | 1 | Use the transfer count |
| cmd_dmahs_i | input | 1 | Use the request/acknowledge handshake |
| tx_data_i | input | 16 | Transmit stream data |
| tx_valid_i | input | 1 | Transmit stream valid |
| tx_ready_o | output | 1 | Transmit word taken |
| rx_data_o | output | 16 | Receive stream data |
| rx_valid_o | output | 1 | Receive word valid pulse |
| busy_o | output | 1 | Transfer in progress |
| tr_rdy_o | output | 1 | Word finished pulse |
| dav_o | output | 1 | Read word available |
| rd_word_o | output | 16 | Last word read |
| ata_cs_o | output | 1 | Chip-select (active high) |
| ata_addr_o | output | 3 | Bus register address |
| ata_rd_o | output | 1 | Read strobe (active high) |
| ata_wr_o | output | 1 | Write strobe (active high) |
| ata_dout_o | output | 16 | Bus write data |
| ata_doe_o | output | 1 | Bus data output enable |
| ata_din_i | input | 16 | Bus read data |
| ata_dmarq_i | input | 1 | DMA request from the drive |
| ata_dmack_o | output | 1 | DMA acknowledge |

## Verification
Every result has a fixed cycle. Busy shows in the first sample after the edge that takes the command. Data-available, the read word and receive-valid show in the first sample after the edge where the read strobe falls. Transmitter-ready comes one sample before busy falls. The bench samples on the falling clock edge, so each port value comes from exactly one rising edge. It counts the setup, strobe and hold cycles of each word from the chip-select and strobe pins themselves, and it compares those counts and the total busy length against values worked out from the programmed timing. The bus responder and the transmit stream change their values only between the edges that use them, so any capture one cycle early or late yields a different word.

// File: rtl/ata_host_pkg.sv
package ata_host_pkg;

    parameter int TW = 5;   // timing count width
    parameter int AW = 3;   // drive register address width
    parameter int DW = 16;  // data word width
    parameter int XW = 17;  // transfer count width (up to 65536 words)

    typedef enum logic [2:0] {
        PH_IDLE, PH_WAIT, PH_SETUP, PH_STROBE, PH_HOLD, PH_WEND
    } phase_e;

    typedef struct packed {
        logic          en;
        logic [TW-1:0] pio_setup;
        logic [TW-1:0] pio_strobe;
        logic [TW-1:0] pio_hold;
        logic [TW-1:0] dma_strobe;
        logic [TW-1:0] dma_hold;
    } timing_t;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          rd;
        logic [DW-1:0] data;
        logic          stream;
        logic          dma_hs;
    } cmd_t;

    // Next bus phase; empty setup/hold phases are skipped, strobe never is.
    function automatic phase_e phase_after(phase_e p, logic has_setup, logic has_hold);
        case (p)
            PH_WAIT:   return has_setup ? PH_SETUP : PH_STROBE;
            PH_SETUP:  return PH_STROBE;
            PH_STROBE: return has_hold ? PH_HOLD : PH_WEND;
            PH_HOLD:   return PH_WEND;
            default:   return PH_IDLE;
        endcase
    endfunction

    // True in the last cycle of a phase of length len (0 behaves as 1).
    function automatic logic len_reached(logic [TW-1:0] cnt, logic [TW-1:0] len);
        return ({1'b0, cnt} + {{TW{1'b0}}, 1'b1}) >= {1'b0, len};
    endfunction

endpackage

// File: rtl/ata_host_regs.sv
module ata_host_regs
    import ata_host_pkg::*;
#(
    parameter int XFER_W = XW
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cfg_wr_i,
    input  timing_t           cfg_i,
    input  logic              cnt_wr_i,
    input  logic [XFER_W-1:0] cnt_i,
    output timing_t           timing_o,
    output logic [XFER_W-1:0] words_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            timing_o <= '0;
            words_o  <= XFER_W'(1);
        end else begin
            if (cfg_wr_i) timing_o <= cfg_i;
            if (cnt_wr_i) words_o  <= cnt_i;
        end
    end
endmodule

// File: rtl/ata_phase_timer.sv
module ata_phase_timer
    import ata_host_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          clear_i,
    input  logic [TW-1:0] len_i,
    output logic          last_o
);
    logic [TW-1:0] cnt_q;

    assign last_o = len_reached(cnt_q, len_i);

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i) cnt_q <= '0;
        else if (!last_o)     cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ata_cycle_fsm.sv
module ata_cycle_fsm
    import ata_host_pkg::*;
#(
    parameter int XFER_W = XW
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  timing_t           tcfg_i,
    input  logic [XFER_W-1:0] words_i,
    input  logic              cmd_wr_i,
    input  cmd_t              cmd_i,
    input  logic              multi_i,
    input  logic              tx_valid_i,
    input  logic [DW-1:0]     tx_data_i,
    input  logic              dmarq_i,
    input  logic              ph_last_i,
    output phase_e            phase_o,
    output logic [TW-1:0]     len_o,
    output logic              ph_clear_o,
    output cmd_t              cur_o,
    output logic [DW-1:0]     wdata_o,
    output logic              accept_o,
    output logic              cap_o,
    output logic              tx_ready_o
);
    phase_e            nxt;
    logic [XFER_W-1:0] rem_q;
    logic [TW-1:0]     setup_len, strobe_len, hold_len;
    logic              go;

    assign setup_len  = cur_o.dma_hs ? '0 : tcfg_i.pio_setup;
    assign strobe_len = cur_o.dma_hs ? tcfg_i.dma_strobe : tcfg_i.pio_strobe;
    assign hold_len   = cur_o.dma_hs ? tcfg_i.dma_hold   : tcfg_i.pio_hold;

    assign accept_o   = cmd_wr_i && tcfg_i.en && (phase_o == PH_IDLE);
    assign go         = (!cur_o.stream || cur_o.rd || tx_valid_i) && (!cur_o.dma_hs || dmarq_i);
    assign tx_ready_o = (phase_o == PH_WAIT) && go && cur_o.stream && !cur_o.rd;
    assign cap_o      = (phase_o == PH_STROBE) && ph_last_i && cur_o.rd;
    assign ph_clear_o = (nxt != phase_o);

    always_comb begin
        case (phase_o)
            PH_SETUP:  len_o = setup_len;
            PH_STROBE: len_o = strobe_len;
            PH_HOLD:   len_o = hold_len;
            default:   len_o = '0;
        endcase
    end

    always_comb begin
        nxt = phase_o;
        case (phase_o)
            PH_IDLE:   if (accept_o) nxt = PH_WAIT;
            PH_WAIT:   if (go) nxt = phase_after(phase_o, setup_len != '0, hold_len != '0);
            PH_SETUP, PH_STROBE, PH_HOLD:
                       if (ph_last_i) nxt = phase_after(phase_o, setup_len != '0, hold_len != '0);
            PH_WEND:   nxt = (rem_q > XFER_W'(1)) ? PH_WAIT : PH_IDLE;
            default:   nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_o <= PH_IDLE;
            rem_q   <= '0;
            cur_o   <= '0;
            wdata_o <= '0;
        end else begin
            phase_o <= nxt;
            if (accept_o) begin
                cur_o <= cmd_i;
                rem_q <= multi_i ? words_i : XFER_W'(1);
            end
            if (phase_o == PH_WEND) rem_q <= rem_q - 1'b1;
            if (phase_o == PH_WAIT && go)
                wdata_o <= (cur_o.stream && !cur_o.rd) ? tx_data_i : cur_o.data;
        end
    end
endmodule

// File: rtl/ata_pio_host.sv
module ata_pio_host
    import ata_host_pkg::*;
#(
    parameter int TIME_W = TW,
    parameter int ADDR_W = AW,
    parameter int DATA_W = DW,
    parameter int XFER_W = XW
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cfg_wr_i,
    input  logic              cfg_en_i,
    input  logic [TIME_W-1:0] cfg_pio_setup_i,
    input  logic [TIME_W-1:0] cfg_pio_strobe_i,
    input  logic [TIME_W-1:0] cfg_pio_hold_i,
    input  logic [TIME_W-1:0] cfg_dma_strobe_i,
    input  logic [TIME_W-1:0] cfg_dma_hold_i,
    input  logic              cnt_wr_i,
    input  logic [XFER_W-1:0] cnt_words_i,
    input  logic              cmd_wr_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic              cmd_read_i,
    input  logic [DATA_W-1:0] cmd_data_i,
    input  logic              cmd_stream_i,
    input  logic              cmd_multi_i,
    input  logic              cmd_dmahs_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              busy_o,
    output logic              tr_rdy_o,
    output logic              dav_o,
    output logic [DATA_W-1:0] rd_word_o,
    output logic              ata_cs_o,
    output logic [ADDR_W-1:0] ata_addr_o,
    output logic              ata_rd_o,
    output logic              ata_wr_o,
    output logic [DATA_W-1:0] ata_dout_o,
    output logic              ata_doe_o,
    input  logic [DATA_W-1:0] ata_din_i,
    input  logic              ata_dmarq_i,
    output logic              ata_dmack_o
);
    timing_t           cfg_in, timing_q;
    logic [XFER_W-1:0] words_q;
    cmd_t              cmd_in, cur;
    phase_e            phase;
    logic [TW-1:0]     ph_len;
    logic              ph_clear, ph_last, accept, cap, host_en;

    assign cfg_in  = '{en: cfg_en_i, pio_setup: cfg_pio_setup_i, pio_strobe: cfg_pio_strobe_i,
                       pio_hold: cfg_pio_hold_i, dma_strobe: cfg_dma_strobe_i, dma_hold: cfg_dma_hold_i};
    assign cmd_in  = '{addr: cmd_addr_i, rd: cmd_read_i, data: cmd_data_i,
                       stream: cmd_stream_i, dma_hs: cmd_dmahs_i};
    assign host_en = timing_q.en;

    ata_host_regs #(.XFER_W(XFER_W)) regs_i (
        .clk_i(clk_i), .rst_i(rst_i), .cfg_wr_i(cfg_wr_i), .cfg_i(cfg_in),
        .cnt_wr_i(cnt_wr_i), .cnt_i(cnt_words_i), .timing_o(timing_q), .words_o(words_q)
    );

    ata_phase_timer timer_i (
        .clk_i(clk_i), .rst_i(rst_i), .clear_i(ph_clear), .len_i(ph_len), .last_o(ph_last)
    );

    ata_cycle_fsm #(.XFER_W(XFER_W)) fsm_i (
        .clk_i(clk_i), .rst_i(rst_i), .tcfg_i(timing_q), .words_i(words_q),
        .cmd_wr_i(cmd_wr_i), .cmd_i(cmd_in), .multi_i(cmd_multi_i),
        .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i), .dmarq_i(ata_dmarq_i),
        .ph_last_i(ph_last), .phase_o(phase), .len_o(ph_len), .ph_clear_o(ph_clear),
        .cur_o(cur), .wdata_o(ata_dout_o), .accept_o(accept), .cap_o(cap),
        .tx_ready_o(tx_ready_o)
    );

    assign ata_cs_o    = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    assign ata_addr_o  = ata_cs_o ? cur.addr : '0;
    assign ata_rd_o    = (phase == PH_STROBE) && cur.rd;
    assign ata_wr_o    = (phase == PH_STROBE) && !cur.rd;
    assign ata_doe_o   = ata_cs_o && !cur.rd;
    assign ata_dmack_o = ata_cs_o && cur.dma_hs;
    assign busy_o      = (phase != PH_IDLE);
    assign tr_rdy_o    = (phase == PH_WEND);
    assign rx_data_o   = rd_word_o;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rd_word_o  <= '0;
            dav_o      <= 1'b0;
            rx_valid_o <= 1'b0;
        end else begin
            rx_valid_o <= 1'b0;
            if (accept) dav_o <= 1'b0;
            if (cap) begin
                rd_word_o  <= ata_din_i;
                dav_o      <= 1'b1;
                rx_valid_o <= cur.stream;
            end
        end
    end
endmodule

// File: rtl/ata_pio_host_chk.sv
module ata_pio_host_chk (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       cmd_wr,
    input logic       busy,
    input logic       tr_rdy,
    input logic       dav,
    input logic       cs,
    input logic       rd,
    input logic       wr,
    input logic [2:0] addr
);
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(rd && wr));        // R2
    AST_STROBE_INSIDE_CS:  assert property (@(posedge clk) disable iff (rst) (rd || wr) |-> cs);  // R2
    AST_ADDR_HELD:         assert property (@(posedge clk) disable iff (rst) (cs && $past(cs)) |-> $stable(addr)); // R2
    AST_DAV_AT_READ_END:   assert property (@(posedge clk) disable iff (rst) ($past(rd) && !rd) |-> dav); // R3
    AST_READY_BEFORE_IDLE: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> $past(tr_rdy)); // R5
    AST_READY_ONE_CYCLE:   assert property (@(posedge clk) disable iff (rst) tr_rdy |=> !tr_rdy); // R5
    AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (rst) (!busy && cmd_wr && !en) |=> !busy); // R8
endmodule

bind ata_pio_host ata_pio_host_chk chk_i (
    .clk(clk_i), .rst(rst_i), .en(host_en), .cmd_wr(cmd_wr_i), .busy(busy_o),
    .tr_rdy(tr_rdy_o), .dav(dav_o), .cs(ata_cs_o), .rd(ata_rd_o), .wr(ata_wr_o),
    .addr(ata_addr_o)
);

// File: tb/ata_pio_host_tb_top.sv
`timescale 1ns/1ps
module ata_pio_host_tb_top;
    logic clk = 1'b0, rst = 1'b1;
    always #2 clk = ~clk;

    logic        cfg_wr = 0, cfg_en = 0, cnt_wr = 0, cmd_wr = 0;
    logic [4:0]  c_s = 0, c_t = 0, c_h = 0, c_ds = 0, c_dh = 0;
    logic [16:0] cnt_words = 0;
    logic [2:0]  cmd_addr = 0;
    logic        cmd_read = 0, cmd_stream = 0, cmd_multi = 0, cmd_dmahs = 0;
    logic [15:0] cmd_data = 0;
    logic        tx_valid = 1, dmarq = 1;
    logic        tx_ready_o, rx_valid_o, busy_o, tr_rdy_o, dav_o;
    logic        ata_cs_o, ata_rd_o, ata_wr_o, ata_doe_o, ata_dmack_o;
    logic [15:0] rx_data_o, rd_word_o, ata_dout_o, ata_din, tx_data;
    logic [2:0]  ata_addr_o;

    int nchk = 0, nfail = 0, cyc = 0;
    int rd_cnt = 0, tx_idx = 0, widx = 0, nrx = 0;
    int pre, stw, post, busy_cyc, cs_tot, addr_bad, dmack_bad, oe_bad, dav_bad, order_bad;
    bit seen, tx_pend, prev_busy, prev_tr, prev_rd, first_busy;
    logic [2:0] exp_addr;
    bit exp_hs;
    int w_pre[8], w_stw[8], w_post[8];
    logic [15:0] wlog[8], rxlog[8];

    function automatic logic [15:0] resp(int k);
        return 16'(32'h5A00 + k * 7);
    endfunction
    function automatic logic [15:0] txv(int k);
        return 16'(32'hC000 + k * 17);
    endfunction

    assign ata_din = ata_rd_o ? resp(rd_cnt) : 16'hDEAD;
    assign tx_data = txv(tx_idx);

    ata_pio_host dut_i (
        .clk_i(clk), .rst_i(rst), .cfg_wr_i(cfg_wr), .cfg_en_i(cfg_en),
        .cfg_pio_setup_i(c_s), .cfg_pio_strobe_i(c_t), .cfg_pio_hold_i(c_h),
        .cfg_dma_strobe_i(c_ds), .cfg_dma_hold_i(c_dh), .cnt_wr_i(cnt_wr),
        .cnt_words_i(cnt_words), .cmd_wr_i(cmd_wr), .cmd_addr_i(cmd_addr),
        .cmd_read_i(cmd_read), .cmd_data_i(cmd_data), .cmd_stream_i(cmd_stream),
        .cmd_multi_i(cmd_multi), .cmd_dmahs_i(cmd_dmahs), .tx_data_i(tx_data),
        .tx_valid_i(tx_valid), .tx_ready_o(tx_ready_o), .rx_data_o(rx_data_o),
        .rx_valid_o(rx_valid_o), .busy_o(busy_o), .tr_rdy_o(tr_rdy_o), .dav_o(dav_o),
        .rd_word_o(rd_word_o), .ata_cs_o(ata_cs_o), .ata_addr_o(ata_addr_o),
        .ata_rd_o(ata_rd_o), .ata_wr_o(ata_wr_o), .ata_dout_o(ata_dout_o),
        .ata_doe_o(ata_doe_o), .ata_din_i(ata_din), .ata_dmarq_i(dmarq),
        .ata_dmack_o(ata_dmack_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            finish_run();
        end
    end

    // Pin monitor: samples on the falling edge
    always @(negedge clk) if (!rst) begin
        if (tx_pend) tx_idx++;
        tx_pend = tx_ready_o;
        if (busy_o) busy_cyc++;
        if (ata_cs_o) begin
            cs_tot++;
            if (ata_addr_o != exp_addr) addr_bad++;
            if (ata_dmack_o != exp_hs) dmack_bad++;
            if (ata_rd_o || ata_wr_o) begin
                stw++; seen = 1;
                if (ata_wr_o && widx < 8) wlog[widx] = ata_dout_o;
                if (ata_wr_o && !ata_doe_o) oe_bad++;
            end else if (!seen) pre++;
            else post++;
        end
        if (prev_rd && !ata_rd_o) begin
            if (!dav_o || rd_word_o != resp(rd_cnt)) dav_bad++;
            rd_cnt++;
        end
        if (rx_valid_o && nrx < 8) begin rxlog[nrx] = rx_data_o; nrx++; end
        if (tr_rdy_o) begin
            if (widx < 8) begin w_pre[widx] = pre; w_stw[widx] = stw; w_post[widx] = post; end
            widx++; pre = 0; stw = 0; post = 0; seen = 0;
        end
        if (prev_busy && !busy_o && !prev_tr) order_bad++;
        prev_busy = busy_o; prev_tr = tr_rdy_o; prev_rd = ata_rd_o;
    end

    task automatic clear_stats();
        widx = 0; nrx = 0; pre = 0; stw = 0; post = 0; seen = 0;
        busy_cyc = 0; cs_tot = 0; addr_bad = 0; dmack_bad = 0; oe_bad = 0;
        dav_bad = 0; order_bad = 0;
    endtask

    task automatic set_cfg(input bit en, input int s, input int t, input int h, input int ds, input int dh);
        @(negedge clk);
        cfg_en = en; c_s = 5'(s); c_t = 5'(t); c_h = 5'(h); c_ds = 5'(ds); c_dh = 5'(dh); cfg_wr = 1;
        @(negedge clk); cfg_wr = 0;
    endtask

    task automatic set_words(input int w);
        @(negedge clk); cnt_words = 17'(w); cnt_wr = 1;
        @(negedge clk); cnt_wr = 0;
    endtask

    task automatic issue(input bit rd, input bit strm, input bit hs, input bit multi,
                         input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        cmd_read = rd; cmd_stream = strm; cmd_dmahs = hs; cmd_multi = multi;
        cmd_addr = a; cmd_data = d; cmd_wr = 1;
        @(negedge clk); cmd_wr = 0; first_busy = busy_o;
    endtask

    task automatic xfer(input bit rd, input bit strm, input bit hs, input bit multi,
                        input logic [2:0] a, input logic [15:0] d);
        @(posedge clk);
        clear_stats(); exp_addr = a; exp_hs = hs;
        issue(rd, strm, hs, multi, a, d);
        while (busy_o) @(negedge clk);
        @(posedge clk);
    endtask

    // Full check of a PIO transfer against the programmed timing
    task automatic check_pio(input int s, input int t, input int h, input int words,
                             input bit rd, input logic [15:0] d, input int rdbase);
        int te = (t == 0) ? 1 : t;
        chk(first_busy == 1, "R6 busy after accept", first_busy, 1);
        chk(widx == words, "R7 word count", widx, words);
        chk(busy_cyc == words * (2 + s + te + h), "R6 busy length", busy_cyc, words * (2 + s + te + h));
        chk(order_bad == 0, "R5 ready before busy falls", order_bad, 0);
        chk(addr_bad == 0, "R2 address held", addr_bad, 0);
        for (int i = 0; i < words && i < 8; i++) begin
            chk(w_pre[i] == s, "R2 setup cycles", w_pre[i], s);
            chk(w_stw[i] == te, "R2 strobe cycles", w_stw[i], te);
            chk(w_post[i] == h, "R2 hold cycles", w_post[i], h);
            if (!rd) chk(wlog[i] == d, "R4 write data", wlog[i], d);
        end
        if (rd) begin
            chk(dav_bad == 0, "R3 capture at strobe end", dav_bad, 0);
            chk(dav_o == 1, "R3 dav set", dav_o, 1);
            chk(rd_word_o == resp(rdbase + words - 1), "R3 read word", rd_word_o, resp(rdbase + words - 1));
        end else begin
            chk(oe_bad == 0, "R4 output enable", oe_bad, 0);
        end
    endtask

    initial begin
        int s, t, h, w, base;
        bit rd;
        logic [15:0] d;
        logic [2:0] a;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(!busy_o && !tr_rdy_o && !dav_o && !ata_cs_o && !ata_rd_o && !ata_wr_o,
            "R1 reset outputs", {busy_o, tr_rdy_o, dav_o, ata_cs_o, ata_rd_o, ata_wr_o}, 0);
        chk(rd_word_o == 0, "R1 read word", rd_word_o, 0);

        // R8: enable still clear after reset, command ignored
        @(posedge clk); clear_stats(); exp_addr = 3'd2; exp_hs = 0;
        issue(1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 16'h1234);
        repeat (8) @(negedge clk);
        chk(busy_cyc == 0 && cs_tot == 0, "R8 disabled no cycle", busy_cyc + cs_tot, 0);

        // R2..R6 directed: slow, middle, fast PIO timings
        set_cfg(1, 4, 19, 4, 4, 0);
        base = rd_cnt; xfer(1, 0, 0, 0, 3'd7, 16'h0);
        check_pio(4, 19, 4, 1, 1, 16'h0, base);
        set_cfg(1, 1, 6, 2, 4, 0);
        xfer(0, 0, 0, 0, 3'd1, 16'hBEEF);
        check_pio(1, 6, 2, 1, 0, 16'hBEEF, rd_cnt);
        chk(dav_o == 0, "R3 dav cleared by next command", dav_o, 0);
        set_cfg(1, 1, 5, 0, 4, 0);
        base = rd_cnt; xfer(1, 0, 0, 0, 3'd6, 16'h0);
        check_pio(1, 5, 0, 1, 1, 16'h0, base);
        // corner: all zero -> one-cycle strobe only
        set_cfg(1, 0, 0, 0, 4, 0);
        xfer(0, 0, 0, 0, 3'd3, 16'h00FF);
        check_pio(0, 0, 0, 1, 0, 16'h00FF, rd_cnt);

        // R7: count 0 runs one word; multi flag clear ignores count
        set_cfg(1, 2, 3, 1, 4, 0);
        set_words(0);
        xfer(0, 0, 0, 1, 3'd4, 16'h4444);
        chk(widx == 1, "R7 count zero gives one word", widx, 1);
        set_words(3);
        xfer(0, 0, 0, 0, 3'd4, 16'h4445);
        chk(widx == 1, "R7 single without multi", widx, 1);

        // R9: second command while busy is ignored
        @(posedge clk); clear_stats(); exp_addr = 3'd5; exp_hs = 0;
        issue(0, 0, 0, 0, 3'd5, 16'h5555);
        repeat (2) @(negedge clk);
        cmd_addr = 3'd2; cmd_read = 1; cmd_wr = 1;
        @(negedge clk); cmd_wr = 0;
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(widx == 1 && addr_bad == 0 && !busy_o, "R9 busy command ignored", widx * 10 + addr_bad, 10);

        // Random PIO transfers
        for (int k = 0; k < 24; k++) begin
            s = $urandom % 5; t = $urandom % 8; h = $urandom % 5;
            w = 1 + $urandom % 3; rd = 1'($urandom % 2);
            d = 16'($urandom); a = 3'($urandom);
            set_cfg(1, s, t, h, 4, 0);
            set_words(w);
            base = rd_cnt;
            xfer(rd, 0, 0, 1, a, d);
            check_pio(s, t, h, w, rd, d, base);
        end

        // R10: handshake write waits for request, no setup, DMA strobe/hold
        set_cfg(1, 3, 7, 2, 4, 0);
        dmarq = 0;
        fork
            xfer(0, 0, 1, 0, 3'd0, 16'hA5A5);
            begin
                repeat (6) @(negedge clk);
                chk(cs_tot == 0 && busy_o, "R10 waits for request", cs_tot, 0);
                dmarq = 1;
            end
        join
        chk(w_pre[0] == 0, "R10 no setup", w_pre[0], 0);
        chk(w_stw[0] == 4, "R10 DMA strobe", w_stw[0], 4);
        chk(w_post[0] == 0, "R10 DMA hold", w_post[0], 0);
        chk(dmack_bad == 0, "R10 acknowledge with cs", dmack_bad, 0);
        chk(wlog[0] == 16'hA5A5, "R4 handshake write data", wlog[0], 16'hA5A5);

        // R11: stream read with handshake, two words
        set_cfg(1, 1, 3, 1, 2, 1);
        set_words(2);
        base = rd_cnt;
        xfer(1, 1, 1, 1, 3'd0, 16'h0);
        chk(nrx == 2, "R11 receive pulses", nrx, 2);
        chk(rxlog[0] == resp(base) && rxlog[1] == resp(base + 1), "R11 receive data",
            rxlog[1], resp(base + 1));

        // R11: stream write, source stalls first
        set_words(3);
        tx_idx = 0; tx_valid = 0;
        fork
            xfer(0, 1, 0, 1, 3'd0, 16'h0000);
            begin
                repeat (5) @(negedge clk);
                chk(cs_tot == 0, "R11 waits for transmit valid", cs_tot, 0);
                tx_valid = 1;
            end
        join
        chk(widx == 3 && tx_idx == 3, "R11 transmit words taken", tx_idx, 3);
        for (int i = 0; i < 3; i++)
            chk(wlog[i] == txv(i), "R11 stream write data", wlog[i], txv(i));

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule